// File: doc/BRIEF.md
# Multi-Buffer Instruction Fetch Cache

This block sits between an instruction issue stage and a set of 16 interleaved memory banks. It keeps four instruction buffers. Each buffer holds one aligned block of 64 parcels of 16 bits, stored as 16 words of 64 bits, with one word taken from each bank. Every buffer has a beginning-address tag, and all four tags are compared against the parcel address in parallel. On a hit the addressed parcel comes back in the same cycle, whether the jump was forward or backward.

On a miss the block picks a victim buffer in round-robin order and writes the new tag into it. It then asks the memory for the 16 words of the block, always starting with bank 0 and counting upward. Issue waits until every word has arrived. Words may come back in any order.

A context exchange empties all buffers by loading every tag with all ones. No parcel address can match that value. Once a block is resident, later changes to memory are not seen until that buffer is replaced.

Top module: `ibuf_fetch_cache`

## Requirements
- R1: A parcel address splits into a parcel select in bits [1:0], a word (bank) index in bits [5:2], and a tag in the bits above. When an idle fetch hits a resident block, `fetch_valid` is high in that same cycle and `fetch_parcel` carries the addressed parcel. The parcel is bits [16*p+15:16*p] of the stored word, where p is the parcel select.
- R2: A legal miss while idle starts a fill on the next clock edge. From the following cycle, `mem_req` is high for exactly 16 consecutive cycles. The word addresses are {tag, bank}, with the bank running 0, 1, …, 15.
- R3: While a fill is in progress, `fetch_valid` stays low for every address, including addresses that hit. Returned words may arrive in any order. The fill ends on the edge where the last missing bank is written, and a hit may be valid in the next cycle.
- R4: The victim buffer is chosen by a pointer that is 0 after reset and advances by one, modulo 4, after each completed fill. The other three buffers keep their contents.
- R5: A fetch that hits never raises `mem_req`, for any order of forward and backward jumps among resident blocks.
- R6: `inval` loads every tag with the reserved all-ones value and abandons any fill in progress without advancing the pointer. From the next cycle no fetch is valid until a new fill completes. Memory responses that arrive while no fill is in progress are ignored.
- R7: An address whose tag is all ones is illegal. It is never valid and never starts a fill.
- R8: No two buffers ever hold the same tag.
- R9: A resident parcel keeps the value it was filled with, even if memory later changes.
- R10: After reset `fetch_valid` and `mem_req` are low and all buffers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval | input | 1 | Empty all buffers (context exchange) |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Parcel address |
| fetch_valid | output | 1 | Parcel delivered this cycle |
| fetch_parcel | output | PARCEL_W | Delivered parcel |
| mem_req | output | 1 | Word request to memory |
| mem_addr | output | ADDR_W-2 | Requested word address {tag, bank} |
| mem_rvalid | input | 1 | Returned word is valid |
| mem_rbank | input | 4 | Bank index of the returned word |
| mem_rdata | input | 64 | Returned word |

## Verification
Some results are due in the same cycle as their cause. A hit gives `fetch_valid` and the parcel in the cycle the address is presented, and `mem_req` follows from the fill counter within the cycle. Other results are due one edge later. The first word request appears one cycle after a miss is seen. A hit becomes valid in the cycle after the edge that takes the last bank word. The effect of `inval` shows in the cycle after it is asserted. The bench drives every input at the falling edge and compares all outputs 1 ns later against a behavioural model. The model is then advanced at the rising edge using the same driven values, so each expected value lands in exactly the cycle the requirement names.

// File: rtl/ibuf_fetch_cache.sv
module ibuf_fetch_cache #(
  parameter int ADDR_W   = 22,
  parameter int NBUF     = 4,
  parameter int WORDS    = 16,
  parameter int PPW      = 4,
  parameter int PARCEL_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inval,
  input  logic                           fetch_req,
  input  logic [ADDR_W-1:0]              fetch_addr,
  output logic                           fetch_valid,
  output logic [PARCEL_W-1:0]            fetch_parcel,
  output logic                           mem_req,
  output logic [ADDR_W-$clog2(PPW)-1:0]  mem_addr,
  input  logic                           mem_rvalid,
  input  logic [$clog2(WORDS)-1:0]       mem_rbank,
  input  logic [PPW*PARCEL_W-1:0]        mem_rdata
);
  localparam int PSEL_W = $clog2(PPW);
  localparam int BANK_W = $clog2(WORDS);
  localparam int OFF_W  = PSEL_W + BANK_W;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int WORD_W = PPW * PARCEL_W;
  localparam int PTR_W  = $clog2(NBUF);
  localparam int CNT_W  = BANK_W + 1;

  logic [TAG_W:0]      tag_q [NBUF];
  logic [WORD_W-1:0]   store [NBUF][WORDS];
  logic                filling;
  logic [PTR_W-1:0]    fill_buf, rr;
  logic [CNT_W-1:0]    req_cnt;
  logic [WORDS-1:0]    got, got_next;

  wire [TAG_W-1:0]  a_tag  = fetch_addr[ADDR_W-1:OFF_W];
  wire [BANK_W-1:0] a_bank = fetch_addr[OFF_W-1:PSEL_W];
  wire [PSEL_W-1:0] a_psel = fetch_addr[PSEL_W-1:0];
  wire              legal  = ~&a_tag;

  logic             hit;
  logic [PTR_W-1:0] hit_buf;
  always_comb begin
    hit = 1'b0;
    hit_buf = '0;
    for (int b = 0; b < NBUF; b++)
      if (tag_q[b] == {1'b0, a_tag}) begin
        hit = 1'b1;
        hit_buf = PTR_W'(b);
      end
  end

  wire [WORD_W-1:0] sel_word = store[hit_buf][a_bank];
  assign fetch_parcel = sel_word[int'(a_psel)*PARCEL_W +: PARCEL_W];
  assign fetch_valid  = fetch_req & ~filling & hit;

  wire start_fill = ~filling & fetch_req & ~hit & legal & ~inval;
  assign got_next = got | ((filling & mem_rvalid) ? (WORDS'(1) << mem_rbank) : '0);
  wire fill_done  = filling & (&got_next);

  assign mem_req  = filling & ~req_cnt[BANK_W];
  assign mem_addr = {tag_q[fill_buf][TAG_W-1:0], req_cnt[BANK_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBUF; b++) tag_q[b] <= '1;
      filling  <= 1'b0;
      fill_buf <= '0;
      rr       <= '0;
      req_cnt  <= '0;
      got      <= '0;
    end else if (inval) begin
      for (int b = 0; b < NBUF; b++) tag_q[b] <= '1;
      filling <= 1'b0;
      req_cnt <= '0;
      got     <= '0;
    end else if (start_fill) begin
      tag_q[rr] <= {1'b0, a_tag};
      fill_buf  <= rr;
      filling   <= 1'b1;
      req_cnt   <= '0;
      got       <= '0;
    end else if (filling) begin
      if (mem_req) req_cnt <= req_cnt + CNT_W'(1);
      got <= got_next;
      if (fill_done) begin
        filling <= 1'b0;
        rr      <= rr + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk)
    if (rst_n && !inval && filling && mem_rvalid)
      store[fill_buf][mem_rbank] <= mem_rdata;

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NBUF; i++)
      for (int j = i + 1; j < NBUF; j++)
        if (tag_q[i] == tag_q[j] && !tag_q[i][TAG_W]) dup = 1'b1;
  end

  AST_NO_DUP_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n) !dup); // R8
  AST_QUIET_DURING_FILL: assert property (@(posedge clk) disable iff (!rst_n) filling |-> !fetch_valid); // R3
  AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) inval |=> !fetch_valid); // R6
  AST_FILL_BANK0_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_req) |-> mem_addr[BANK_W-1:0] == '0); // R2
  AST_FILL_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> mem_addr[BANK_W-1:0] == BANK_W'($past(mem_addr[BANK_W-1:0]) + 1'b1)); // R2
  AST_ILLEGAL_NEVER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && (&fetch_addr[ADDR_W-1:OFF_W])) |-> !fetch_valid); // R7
  AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n) fetch_valid |=> !mem_req); // R5
endmodule

// File: tb/tb_ibuf_fetch_cache.sv
`timescale 1ns/1ps
module tb_ibuf_fetch_cache;
  logic clk = 1'b0, rst_n = 1'b0, inval = 1'b0, fetch_req = 1'b0;
  logic [21:0] fetch_addr = '0;
  logic fetch_valid, mem_req, mem_rvalid = 1'b0;
  logic [15:0] fetch_parcel;
  logic [19:0] mem_addr;
  logic [3:0]  mem_rbank = '0;
  logic [63:0] mem_rdata = '0;

  always #2 clk = ~clk;

  ibuf_fetch_cache dut (
    .clk(clk), .rst_n(rst_n), .inval(inval), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_parcel(fetch_parcel), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rbank(mem_rbank), .mem_rdata(mem_rdata));

  int checks = 0, failures = 0, cyc = 0, ver = 0;
  string cur = "R10";
  logic last_valid;
  int req_seen;
  logic [19:0] pending[$];

  int mtag[4];
  logic [15:0] mdata[4][64];
  bit mgot[16];
  bit mbusy;
  int mfilltag, mfb, mrr, mreqcnt;

  function automatic logic [15:0] memparcel(input int p);
    return 16'(p * 13 + (p >> 5) + ver * 977 + 3);
  endfunction
  function automatic logic [63:0] memword(input logic [19:0] wa);
    logic [63:0] w;
    for (int i = 0; i < 4; i++) w[i*16 +: 16] = memparcel(int'(wa) * 4 + i);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic req, input logic [21:0] a, input logic inv);
    int hitb, ftag;
    bit legal, ev, ereq, dreq, rv, all;
    logic [19:0] dma;
    logic [3:0] rb;
    logic [63:0] rd;
    fetch_req = req; fetch_addr = a; inval = inv;
    rv = 1'b0; rb = '0; rd = '0;
    if (pending.size() > 0 && (cyc % 4) != 3) begin
      int idx = (cyc * 7) % pending.size();
      rv = 1'b1; rb = pending[idx][3:0]; rd = memword(pending[idx]);
      pending.delete(idx);
    end
    mem_rvalid = rv; mem_rbank = rb; mem_rdata = rd;
    #1;
    ftag = int'(a >> 6);
    legal = (ftag != 16'hFFFF);
    hitb = -1;
    for (int b = 0; b < 4; b++) if (mtag[b] == ftag) hitb = b;
    ev = req && !mbusy && hitb >= 0;
    ereq = mbusy && mreqcnt < 16;
    chk(fetch_valid == ev, cur, "fetch_valid", fetch_valid, ev);
    if (ev) chk(fetch_parcel == mdata[hitb][a[5:0]], cur, "fetch_parcel", fetch_parcel, mdata[hitb][a[5:0]]);
    chk(mem_req == ereq, "R2", "mem_req", mem_req, ereq);
    if (ereq) chk(mem_addr == 20'(mfilltag * 16 + mreqcnt), "R2", "mem_addr", mem_addr, mfilltag * 16 + mreqcnt);
    last_valid = fetch_valid;
    dreq = mem_req; dma = mem_addr;
    if (dreq) req_seen++;
    @(posedge clk);
    if (inv) begin
      for (int b = 0; b < 4; b++) mtag[b] = -1;
      mbusy = 1'b0;
    end else if (mbusy) begin
      if (mreqcnt < 16) mreqcnt++;
      if (rv) begin
        for (int i = 0; i < 4; i++) mdata[mfb][int'(rb) * 4 + i] = rd[i*16 +: 16];
        mgot[rb] = 1'b1;
      end
      all = 1'b1;
      for (int k = 0; k < 16; k++) if (!mgot[k]) all = 1'b0;
      if (all) begin mbusy = 1'b0; mrr = (mrr + 1) % 4; end
    end else if (req && hitb < 0 && legal) begin
      mbusy = 1'b1; mfilltag = ftag; mfb = mrr; mtag[mrr] = ftag; mreqcnt = 0;
      for (int k = 0; k < 16; k++) mgot[k] = 1'b0;
    end
    if (dreq) pending.push_back(dma);
    cyc++;
    @(negedge clk);
  endtask

  task automatic fetch_wait(input logic [21:0] a, output int waited);
    waited = 0;
    step(1'b1, a, 1'b0);
    while (!last_valid && waited < 200) begin
      step(1'b1, a, 1'b0);
      waited++;
    end
    chk(last_valid == 1'b1, cur, "eventual fetch_valid", last_valid, 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
  endtask

  localparam logic [21:0] A = 22'h0012 << 6, B = 22'h0345 << 6, C = 22'h0A01 << 6,
                          D = 22'h1F00 << 6, E = 22'h2222 << 6;

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w;
    logic [15:0] old;
    for (int b = 0; b < 4; b++) mtag[b] = -1;
    mbusy = 1'b0; mrr = 0; mreqcnt = 16; mfilltag = 0; mfb = 0;
    repeat (4) @(negedge clk);
    #1;
    chk(fetch_valid == 1'b0, "R10", "fetch_valid in reset", fetch_valid, 0);
    chk(mem_req == 1'b0, "R10", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cur = "R10";
    step(1'b1, A + 22'd5, 1'b0);
    chk(last_valid == 1'b0, "R10", "first fetch after reset misses", last_valid, 0);

    cur = "R2";
    req_seen = 0;
    fetch_wait(A + 22'd5, w);
    chk(req_seen == 16, "R2", "words requested per fill", req_seen, 16);

    cur = "R1";
    for (int p = 0; p < 64; p++) step(1'b1, A + 22'(p), 1'b0);

    cur = "R3";
    step(1'b1, B + 22'd9, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, A + 22'(i), 1'b0);
    chk(last_valid == 1'b1, "R3", "hit valid after fill ends", last_valid, 1);
    fetch_wait(C + 22'd63, w);
    fetch_wait(D, w);

    cur = "R5";
    req_seen = 0;
    for (int i = 0; i < 48; i++) begin
      logic [21:0] base;
      case ((i * 3) % 4)
        0: base = A; 1: base = B; 2: base = C; default: base = D;
      endcase
      step(1'b1, base + 22'((63 - i * 5) & 63), 1'b0);
    end
    chk(req_seen == 0, "R5", "requests while hitting", req_seen, 0);

    cur = "R9";
    old = memparcel(int'(A) + 7);
    ver = 1;
    step(1'b1, A + 22'd7, 1'b0);
    chk(fetch_parcel == old, "R9", "stale parcel kept", fetch_parcel, old);

    cur = "R4";
    fetch_wait(E + 22'd2, w);
    step(1'b1, B, 1'b0);
    chk(last_valid == 1'b1, "R4", "B survives", last_valid, 1);
    step(1'b1, C + 22'd1, 1'b0);
    chk(last_valid == 1'b1, "R4", "C survives", last_valid, 1);
    step(1'b1, D + 22'd2, 1'b0);
    chk(last_valid == 1'b1, "R4", "D survives", last_valid, 1);
    step(1'b1, A, 1'b0);
    chk(last_valid == 1'b0, "R4", "A replaced", last_valid, 0);
    idle(30);

    cur = "R8";
    req_seen = 0;
    for (int p = 0; p < 64; p += 9) step(1'b1, E + 22'(p), 1'b0);
    chk(req_seen == 0, "R8", "resident block not fetched twice", req_seen, 0);

    cur = "R7";
    req_seen = 0;
    for (int i = 0; i < 10; i++) step(1'b1, {16'hFFFF, 6'(i)}, 1'b0);
    chk(req_seen == 0, "R7", "illegal tag requests", req_seen, 0);

    cur = "R6";
    step(1'b0, '0, 1'b1);
    step(1'b1, B, 1'b0);
    chk(last_valid == 1'b0, "R6", "B gone after inval", last_valid, 0);
    for (int i = 0; i < 5; i++) step(1'b1, B, 1'b0);
    step(1'b0, '0, 1'b1);
    idle(40);
    step(1'b1, B + 22'd3, 1'b0);
    chk(last_valid == 1'b0, "R6", "aborted fill not resident", last_valid, 0);
    fetch_wait(B + 22'd3, w);
    for (int p = 0; p < 64; p += 5) step(1'b1, B + 22'(p), 1'b0);
    idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule